// File: doc/BRIEF.md
# Fractional Baud Rate Divisor Generator

This block turns a fast reference clock into the sampling strobe of one serial channel. A host loads a 16-bit integer divisor as two bytes and a 4-bit fraction counted in sixteenths. The block then emits a one-cycle `sample_tick` whose average spacing is (divisor + fraction/16) reference clocks. An optional divide-by-four prescaler sits in front of the divisor and stretches every period by four.

A second strobe, `bit_tick`, marks the end of each bit time. It fires on every 16th, 8th or 4th sample tick, according to the oversampling mode. The fraction is spread over the periods by a small phase accumulator: a period that ends in an accumulator overflow lasts one divisor step longer. Any accepted divisor write restarts the timing from a known phase. Register contents can be read back combinationally through the same select lines.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the register select codes read back low byte (code 0) = 0x01, high byte (code 1) = 0x00 and fraction (code 2) = 0x00, and code 3 reads 0x00. With this divisor of one and no prescale, a sample tick then appears on every reference clock.
- R2: The integer divisor D is {high byte, low byte}. With fraction 0 and the prescaler off, consecutive sample ticks are exactly D clocks apart.
- R3: With fraction f, every sample-tick interval is D or D+1 clocks, and any 16 consecutive intervals sum to exactly 16*D + f.
- R4: A write to the fraction register (code 2) while `frac_access_en` is low leaves the stored fraction unchanged. Only the low four bits of a write are stored, and the upper four read back as zero.
- R5: With `prescale_en` high, every interval and every interval sum is exactly four times the value it has with the prescaler off.
- R6: An integer divisor of zero behaves exactly like a divisor of one.
- R7: `os_mode` 0 gives 16x, 1 gives 8x, and 2 or 3 give 4x. `bit_tick` is high only together with a sample tick, and exactly N sample ticks separate consecutive bit ticks, where N is the selected ratio.
- R8: An accepted write to codes 0, 1 or 2 resets the counter, the accumulator, the prescaler and the oversampling count on the following clock. The first sample tick after it comes 1 + D*S clocks after the write edge (S = 4 with prescale, else 1), with an effective D of at least 1. That first period is never stretched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for write and readback: 0 low byte, 1 high byte, 2 fraction |
| wr_data | input | 8 | Write data |
| frac_access_en | input | 1 | Enables writes to the fraction register |
| prescale_en | input | 1 | Divides the reference clock by four ahead of the divisor |
| os_mode | input | 2 | Oversampling select: 0 16x, 1 8x, 2/3 4x |
| rd_data | output | 8 | Contents of the register at `reg_sel` |
| sample_tick | output | 1 | One-cycle oversampling strobe |
| bit_tick | output | 1 | One-cycle bit-time strobe, coincident with a sample tick |

## Verification
The divider is driven with plain integer divisors, a divisor spanning both bytes, fractions of 1, 5, 8 and 15, a zero divisor, and prescaled versions of some of these. Each case records 16 intervals, and their minimum, maximum and total are compared with the expected values. The total shows whether the fraction is applied the correct number of times. The minimum and maximum show whether the extra clocks are spread one at a time, or lumped together, or missing. The restart latency after each write separates an off-by-one reload from a correct one. The oversampling modes are checked by counting sample ticks between bit ticks.

// File: rtl/fbg_pkg.sv
// Shared encodings for the fractional baud divisor generator.
package fbg_pkg;
    // Register select codes used for both writes and readback.
    typedef enum logic [1:0] {
        REG_DIV_LO = 2'd0,
        REG_DIV_HI = 2'd1,
        REG_FRAC   = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;

    // Oversampling ratio select.
    typedef enum logic [1:0] {
        OS_X16  = 2'd0,
        OS_X8   = 2'd1,
        OS_X4   = 2'd2,
        OS_X4B  = 2'd3
    } os_mode_e;
endpackage

// File: rtl/fbg_regs.sv
// Divisor register file: holds the low and high divisor bytes and the
// fraction nibble, gives combinational readback, and raises a one-cycle
// restart pulse after each accepted write.
// Assumes: synchronous active-low reset, single-cycle write strobe.
module fbg_regs
    import fbg_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int FRAC_W = 4,
    localparam int INT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [1:0]        reg_sel_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic              frac_access_en_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic [INT_W-1:0]  int_div_o,
    output logic [FRAC_W-1:0] frac_o,
    output logic              restart_o
);
    logic [BYTE_W-1:0] lo_q, hi_q;
    logic [FRAC_W-1:0] frac_q;
    logic              accept;

    // Decide whether this write lands in a register.
    always_comb begin
        accept = 1'b0;
        if (wr_en_i) begin
            case (reg_sel_i)
                REG_DIV_LO, REG_DIV_HI: accept = 1'b1;
                REG_FRAC:               accept = frac_access_en_i;
                default:                accept = 1'b0;
            endcase
        end
    end

    // Register storage with reset values giving a divisor of one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q      <= BYTE_W'(1);
            hi_q      <= '0;
            frac_q    <= '0;
            restart_o <= 1'b0;
        end else begin
            restart_o <= accept;
            if (accept) begin
                case (reg_sel_i)
                    REG_DIV_LO: lo_q   <= wr_data_i;
                    REG_DIV_HI: hi_q   <= wr_data_i;
                    REG_FRAC:   frac_q <= wr_data_i[FRAC_W-1:0];
                    default:    ;
                endcase
            end
        end
    end

    // Combinational readback of the selected register.
    always_comb begin
        case (reg_sel_i)
            REG_DIV_LO: rd_data_o = lo_q;
            REG_DIV_HI: rd_data_o = hi_q;
            REG_FRAC:   rd_data_o = {{(BYTE_W-FRAC_W){1'b0}}, frac_q};
            default:    rd_data_o = '0;
        endcase
    end

    assign int_div_o = {hi_q, lo_q};
    assign frac_o    = frac_q;

    // R4
    frac_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && reg_sel_i == REG_FRAC && !frac_access_en_i) |=> $stable(frac_q));
endmodule

// File: rtl/fbg_prescale.sv
// Input-clock prescaler: produces a count enable that is always high when
// the prescaler is off, or high once every PRE_DIV clocks when it is on.
// Assumes: restart realigns the phase so the first enable comes PRE_DIV
// clocks after it.
module fbg_prescale #(
    parameter int PRE_DIV = 4,
    localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic prescale_en_i,
    output logic en_o
);
    logic [PRE_W-1:0] pre_q;
    logic             last;

    assign last = (pre_q == PRE_W'(PRE_DIV - 1));
    assign en_o = !prescale_en_i || last;

    // Free-running phase counter, cleared by reset or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            pre_q <= '0;
        end else if (last) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    // R5
    en_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prescale_en_i && en_o) |=> (!en_o || !prescale_en_i));
endmodule

// File: rtl/fbg_divider.sv
// Fractional divider: counts enabled clocks down from the integer divisor
// and adds the fraction to a phase accumulator on every sample tick. An
// accumulator overflow lengthens the following period by one step.
// Assumes: a zero divisor is handled as one; restart loads a full,
// unstretched period.
module fbg_divider #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic              en_i,
    input  logic [INT_W-1:0]  int_div_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic              sample_tick_o
);
    logic [INT_W-1:0]  cnt_q, eff_div, reload;
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   acc_sum;

    // Effective divisor, next accumulator phase and the reload value.
    always_comb begin
        eff_div = (int_div_i == '0) ? INT_W'(1) : int_div_i;
        acc_sum = {1'b0, acc_q} + {1'b0, frac_i};
        reload  = eff_div - INT_W'(1) + INT_W'(acc_sum[FRAC_W]);
    end

    // Period counter, phase accumulator and registered tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q         <= '0;
            acc_q         <= '0;
            sample_tick_o <= 1'b0;
        end else if (restart_i) begin
            cnt_q         <= eff_div - INT_W'(1);
            acc_q         <= '0;
            sample_tick_o <= 1'b0;
        end else begin
            sample_tick_o <= 1'b0;
            if (en_i) begin
                if (cnt_q == '0) begin
                    sample_tick_o <= 1'b1;
                    cnt_q         <= reload;
                    acc_q         <= acc_sum[FRAC_W-1:0];
                end else begin
                    cnt_q <= cnt_q - INT_W'(1);
                end
            end
        end
    end

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !restart_i |-> (cnt_q <= eff_div));

    // R8
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !sample_tick_o);
endmodule

// File: rtl/fbg_oversample.sv
// Bit-time strobe: counts sample ticks and flags every Nth one, N being
// 16, 8 or 4 according to the mode select.
// Assumes: after a mode change to a smaller ratio an overshooting count
// wraps on the next sample tick.
module fbg_oversample
    import fbg_pkg::*;
#(
    parameter int OS_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart_i,
    input  logic       sample_tick_i,
    input  logic [1:0] os_mode_i,
    output logic       bit_tick_o
);
    logic [OS_W-1:0] os_cnt_q, last_idx;

    // Map the mode to the index of the last sample tick of a bit.
    always_comb begin
        case (os_mode_i)
            OS_X16:  last_idx = OS_W'(15);
            OS_X8:   last_idx = OS_W'(7);
            default: last_idx = OS_W'(3);
        endcase
    end

    assign bit_tick_o = sample_tick_i && (os_cnt_q >= last_idx);

    // Sample-tick counter within one bit time.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            os_cnt_q <= '0;
        end else if (sample_tick_i) begin
            os_cnt_q <= bit_tick_o ? '0 : os_cnt_q + OS_W'(1);
        end
    end

    // R7
    bit_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick_o |=> (os_cnt_q == '0));
endmodule

// File: rtl/frac_baud_gen.sv
// Top of the fractional baud divisor generator: register file, prescaler,
// fractional divider and bit-time strobe, wired in that order.
// Assumes: one reference clock domain, synchronous active-low reset.
module frac_baud_gen #(
    parameter int BYTE_W  = 8,
    parameter int FRAC_W  = 4,
    parameter int PRE_DIV = 4,
    parameter int OS_W    = 4,
    localparam int INT_W  = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        reg_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              frac_access_en,
    input  logic              prescale_en,
    input  logic [1:0]        os_mode,
    output logic [BYTE_W-1:0] rd_data,
    output logic              sample_tick,
    output logic              bit_tick
);
    logic [INT_W-1:0]  int_div;
    logic [FRAC_W-1:0] frac;
    logic              restart, cnt_en;

    fbg_regs #(.BYTE_W(BYTE_W), .FRAC_W(FRAC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .reg_sel_i(reg_sel),
        .wr_data_i(wr_data), .frac_access_en_i(frac_access_en),
        .rd_data_o(rd_data), .int_div_o(int_div), .frac_o(frac),
        .restart_o(restart)
    );

    fbg_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart_i(restart),
        .prescale_en_i(prescale_en), .en_o(cnt_en)
    );

    fbg_divider #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_div (
        .clk(clk), .rst_n(rst_n), .restart_i(restart), .en_i(cnt_en),
        .int_div_i(int_div), .frac_i(frac), .sample_tick_o(sample_tick)
    );

    fbg_oversample #(.OS_W(OS_W)) u_os (
        .clk(clk), .rst_n(rst_n), .restart_i(restart),
        .sample_tick_i(sample_tick), .os_mode_i(os_mode),
        .bit_tick_o(bit_tick)
    );
endmodule

// File: tb/test_frac_baud_gen.sv
module test_frac_baud_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] reg_sel = 2'd3;
    logic [7:0] wr_data = 8'h00;
    logic       frac_access_en = 1'b0;
    logic       prescale_en = 1'b0;
    logic [1:0] os_mode = 2'd0;
    logic [7:0] rd_data;
    logic       sample_tick, bit_tick;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    frac_baud_gen i_frac_baud_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
        .wr_data(wr_data), .frac_access_en(frac_access_en),
        .prescale_en(prescale_en), .os_mode(os_mode), .rd_data(rd_data),
        .sample_tick(sample_tick), .bit_tick(bit_tick)
    );

    typedef struct packed {
        logic [7:0]  lo;
        logic [7:0]  hi;
        logic [3:0]  fr;
        logic        pre;
        logic [31:0] lat;
        logic [31:0] tot;
        logic [31:0] mn;
        logic [31:0] mx;
    } vec_t;

    // lo, hi, frac, prescale, restart latency, 16-interval sum, min, max
    localparam vec_t VECS [9] = '{
        '{8'h05, 8'h00, 4'h0, 1'b0, 32'd6,   32'd80,   32'd5,   32'd5},
        '{8'h03, 8'h01, 4'h0, 1'b0, 32'd260, 32'd4144, 32'd259, 32'd259},
        '{8'h03, 8'h00, 4'h5, 1'b0, 32'd4,   32'd53,   32'd3,   32'd4},
        '{8'h02, 8'h00, 4'hF, 1'b0, 32'd3,   32'd47,   32'd2,   32'd3},
        '{8'h07, 8'h00, 4'h8, 1'b0, 32'd8,   32'd120,  32'd7,   32'd8},
        '{8'h03, 8'h00, 4'h5, 1'b1, 32'd13,  32'd212,  32'd12,  32'd16},
        '{8'h01, 8'h00, 4'h1, 1'b0, 32'd2,   32'd17,   32'd1,   32'd2},
        '{8'h00, 8'h00, 4'h0, 1'b0, 32'd2,   32'd16,   32'd1,   32'd1},
        '{8'h00, 8'h00, 4'h4, 1'b1, 32'd5,   32'd80,   32'd4,   32'd8}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output int v);
        @(negedge clk);
        reg_sel = sel;
        #1 v = int'(rd_data);
    endtask

    // Clocks from the last write edge to the first sample tick.
    task automatic latency(output int n);
        n = 0;
        do begin
            @(posedge clk); #1 n++;
        end while (!sample_tick && n < 5000);
    endtask

    // Wait for a tick, then record n following intervals.
    task automatic measure(input int n, output int tot, output int mn, output int mx);
        int c;
        c = 0;
        while (!sample_tick && c < 5000) begin @(posedge clk); #1 c++; end
        tot = 0; mn = 1 << 30; mx = 0;
        for (int i = 0; i < n; i++) begin
            c = 0;
            do begin @(posedge clk); #1 c++; end while (!sample_tick && c < 5000);
            tot += c;
            if (c < mn) mn = c;
            if (c > mx) mx = c;
        end
    endtask

    // Count sample ticks from one bit tick to the next.
    task automatic os_count(output int n, output int stray);
        int c;
        c = 0; stray = 0;
        while (!bit_tick && c < 5000) begin @(posedge clk); #1 c++; end
        n = 0; c = 0;
        do begin
            @(posedge clk); #1 c++;
            if (bit_tick && !sample_tick) stray++;
            if (sample_tick) n++;
        end while (!bit_tick && c < 5000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (R1..R8 run): actual=timeout expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v, t, mn, mx, n, stray;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset values and tick every clock
        rd(2'd0, v); chk("R1", "low byte reset", v, 1);
        rd(2'd1, v); chk("R1", "high byte reset", v, 0);
        rd(2'd2, v); chk("R1", "fraction reset", v, 0);
        rd(2'd3, v); chk("R1", "unused code", v, 0);
        measure(8, t, mn, mx);
        chk("R1", "post-reset interval sum", t, 8);

        // R2 R3 R5 R6 R8: table of divisor settings
        frac_access_en = 1'b1;
        foreach (VECS[k]) begin
            prescale_en = VECS[k].pre;
            wr(2'd2, {4'h0, VECS[k].fr});
            wr(2'd1, VECS[k].hi);
            wr(2'd0, VECS[k].lo);
            latency(n);
            chk("R8", $sformatf("vec %0d restart latency", k), n, int'(VECS[k].lat));
            measure(16, t, mn, mx);
            chk("R3", $sformatf("vec %0d interval sum (R2 R5 R6)", k), t, int'(VECS[k].tot));
            chk("R3", $sformatf("vec %0d min interval", k), mn, int'(VECS[k].mn));
            chk("R3", $sformatf("vec %0d max interval", k), mx, int'(VECS[k].mx));
        end
        prescale_en = 1'b0;

        // R4: gated and truncated fraction writes
        wr(2'd2, 8'hA7);
        rd(2'd2, v); chk("R4", "upper fraction bits dropped", v, 7);
        frac_access_en = 1'b0;
        wr(2'd2, 8'h09);
        rd(2'd2, v); chk("R4", "gated fraction write ignored", v, 7);
        wr(2'd0, 8'h04);
        measure(16, t, mn, mx);
        chk("R4", "timing keeps old fraction", t, 16 * 4 + 7);
        frac_access_en = 1'b1;

        // R8: restart latency with prescale, divisor 6 without
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h06);
        latency(n); chk("R8", "latency D=6", n, 7);
        prescale_en = 1'b1;
        wr(2'd0, 8'h03);
        latency(n); chk("R8", "latency D=3 prescaled", n, 13);
        prescale_en = 1'b0;

        // R7: oversampling ratios
        wr(2'd0, 8'h02);
        for (int m = 0; m < 4; m++) begin
            os_mode = 2'(m);
            os_count(n, stray);
            os_count(n, stray);
            chk("R7", $sformatf("mode %0d sample ticks per bit", m), n,
                (m == 0) ? 16 : (m == 1) ? 8 : 4);
            chk("R7", $sformatf("mode %0d bit tick without sample tick", m), stray, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule